// File: doc/BRIEF.md
# Byte-Serial Block Transfer Channel

This block is a single-channel DMA engine for byte-wide transfers. A processor sets it up through a narrow byte port. The processor first shifts a start address and an end address into the channel, one byte per write strobe. It then issues a command byte that starts or stops the channel. It can read the current address back one byte per read strobe. While the channel runs, it moves one byte at a time between a byte-wide memory port and a single attached device, and it advances the current address after each byte. The transfer ends when the next address would pass the end address. At that point the channel raises its interrupt and drops busy.

A static `addr_mode` input picks one of three address widths, encoded 0 = 16-bit, 1 = 18-bit, 2 = wide (20-bit). The width decides how many address bytes the loader accepts. It also decides which command bits take effect. On a start, the channel adjusts the addresses: it inserts the bank bits, forces the start address even, and replaces a wrapped end address with all ones. The current-address register keeps the last address moved, so software can find out where a transfer stopped.

Top module: `bytechan_dma`

## Requirements
- R1: After reset, busy, irq and mem_req are low, both addresses are zero, the write byte count is zero, and the readback pointer selects byte 1. The first read therefore returns 0x00.
- R2: In 16-bit and 18-bit modes, each accepted data byte shifts end-address bits 15:8 into the start register and appends the byte to the end register. Four bytes b0..b3 give start=b0b1 and end=b2b3. A fifth and any further byte is ignored.
- R3: In wide mode up to six bytes are accepted. Bytes 1-5 shift end-address bits 15:8 into the start register and set the end register to {old end bits 7:0, byte}. The sixth byte shifts fully into the end register. The result is start={b0[3:0],b1,b2} and end={b3[3:0],b4,b5}. A seventh byte is ignored.
- R4: A read strobe returns the start-address byte picked by a 2-bit pointer (2 selects bits 19:16, zero-extended) and then decrements the pointer. From 0 the pointer reloads to 2 when extended readback is in force, and to 1 otherwise.
- R5: The command byte is decoded as follows: bit 6 (0x40) extended readback, bit 5 (0x20) memory-to-device direction, bit 4 (0x10) go, bit 3 (0x08) stop, bit 2 (0x04) channel-status select, bits 1:0 bank. Stop takes precedence over go. A command with neither bit set changes nothing. Outside wide mode, bits 6 and 2 are masked off. The bank bits count only in 18-bit mode.
- R6: A stop command clears busy, the interrupt and the write byte count, and reloads the readback pointer. It keeps only the extended-readback and status-select bits.
- R7: A go command latches go and direction. If 4 or fewer address bytes were written, both addresses are cut to 16 bits and the bank is placed at bits 17:16. The start address is then forced even.
- R8: At go, if the end address is not above the start address, the end address is ORed with all ones of the active width: 0xFFFF outside wide mode, 0xFFFFF in wide mode.
- R9: With direction set, bytes are read from memory at successive addresses and handed to the device in order. With direction clear, device bytes are written to memory at successive addresses.
- R10: After the byte at the end address moves, irq rises, busy and direction clear, and the start register holds the end address.
- R11: status_from_dev is high exactly when the channel is idle and channel-status select is clear.
- R12: busy reflects the go state. The memory and device handshakes are active only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_mode | input | 2 | Address width select: 0 = 16-bit, 1 = 18-bit, 2 = wide |
| cpu_din | input | 8 | Data or command byte from the processor |
| cpu_data_we | input | 1 | Strobe: shift cpu_din into the address loader |
| cpu_cmd_we | input | 1 | Strobe: apply cpu_din as a command |
| cpu_rd | input | 1 | Strobe: advance the readback pointer |
| cpu_dout | output | 8 | Start-address byte at the readback pointer |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | End-of-transfer interrupt, held until a stop |
| status_from_dev | output | 1 | Status reads should be routed to the device |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_ack | input | 1 | Memory access ready |
| dev_out_valid | output | 1 | Byte to the device is valid |
| dev_out_ready | input | 1 | Device accepts the byte |
| dev_out_data | output | 8 | Byte to the device |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_ready | output | 1 | Channel accepts the device byte |
| dev_in_data | input | 8 | Byte from the device |

## Verification
Some properties are checked on every cycle:
- memory and device handshakes stay idle unless the channel is busy;
- the current address never exceeds the end address while busy;
- each start begins on an even address;
- irq only rises as busy falls;
- a stop leaves the channel idle with its interrupt clear;
- device status routing is never selected while busy.

Other behaviour can only be shown by the bench's scenarios:
- the byte-rippling load in each mode and the ignored extra bytes;
- the readback pointer sequence with and without extended readback;
- bank insertion and end-address saturation;
- the exact address and data order on both transfer directions.

// File: rtl/bchan_pkg.sv
package bchan_pkg;

    localparam int CH_AW        = 20;
    localparam int NARROW_W     = 16;
    localparam int BANK_W       = 2;
    localparam int BYTE_W       = 8;
    localparam int NARROW_BYTES = 4;
    localparam int WIDE_BYTES   = 6;
    localparam int WCNT_W       = $clog2(WIDE_BYTES + 1);
    localparam int RBP_W        = 2;

    // command byte bit positions
    localparam int CB_EXT  = 6;
    localparam int CB_RD   = 5;
    localparam int CB_GO   = 4;
    localparam int CB_STOP = 3;
    localparam int CB_STAT = 2;

    typedef enum logic [1:0] {
        AMODE_16   = 2'd0,
        AMODE_18   = 2'd1,
        AMODE_WIDE = 2'd2
    } amode_e;

    typedef struct packed {
        logic              ext_rb;
        logic              dir_rd;
        logic              go;
        logic              stop;
        logic              stat_sel;
        logic [BANK_W-1:0] bank;
    } cmd_dec_t;

    typedef struct packed {
        logic ext_rb;
        logic dir_rd;
        logic go;
        logic stat_sel;
    } cmd_state_t;

    typedef struct packed {
        logic [CH_AW-1:0] sa;
        logic [CH_AW-1:0] ea;
    } addr_pair_t;

    function automatic logic [CH_AW-1:0] width_mask(input logic [1:0] mode);
        if (mode == AMODE_WIDE)
            return {CH_AW{1'b1}};
        return CH_AW'({NARROW_W{1'b1}});
    endfunction

    function automatic logic [WCNT_W-1:0] byte_limit(input logic [1:0] mode);
        if (mode == AMODE_WIDE)
            return WCNT_W'(WIDE_BYTES);
        return WCNT_W'(NARROW_BYTES);
    endfunction

    // one step of the byte-rippling address loader
    function automatic addr_pair_t load_step(input logic [1:0] mode,
                                             input logic [WCNT_W-1:0] cnt,
                                             input addr_pair_t cur,
                                             input logic [BYTE_W-1:0] b);
        addr_pair_t nx;
        logic [CH_AW-1:0] m;
        m = width_mask(mode);
        if (mode == AMODE_WIDE && cnt == WCNT_W'(WIDE_BYTES - 1)) begin
            nx.sa = cur.sa;
            nx.ea = ((cur.ea << BYTE_W) | CH_AW'(b)) & m;
        end else begin
            nx.sa = ((cur.sa << BYTE_W) | CH_AW'(cur.ea[NARROW_W-1 -: BYTE_W])) & m;
            nx.ea = CH_AW'({cur.ea[BYTE_W-1:0], b}) & m;
        end
        return nx;
    endfunction

    // address adjustment applied when a transfer is started
    function automatic addr_pair_t go_fixup(input logic [1:0] mode,
                                            input logic [WCNT_W-1:0] cnt,
                                            input logic [BANK_W-1:0] bank,
                                            input addr_pair_t cur);
        addr_pair_t nx;
        nx = cur;
        if (cnt <= WCNT_W'(NARROW_BYTES)) begin
            nx.sa = CH_AW'({bank, cur.sa[NARROW_W-1:0]});
            nx.ea = CH_AW'({bank, cur.ea[NARROW_W-1:0]});
        end
        nx.sa[0] = 1'b0;
        if (nx.ea <= nx.sa)
            nx.ea = nx.ea | width_mask(mode);
        return nx;
    endfunction

endpackage

// File: rtl/bchan_cmd_decode.sv
module bchan_cmd_decode
    import bchan_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic [1:0]        mode,
    output cmd_dec_t          dec
);
    logic wide;
    assign wide = (mode == AMODE_WIDE);

    always_comb begin
        dec.ext_rb   = cmd_byte[CB_EXT] & wide;
        dec.dir_rd   = cmd_byte[CB_RD];
        dec.go       = cmd_byte[CB_GO];
        dec.stop     = cmd_byte[CB_STOP];
        dec.stat_sel = cmd_byte[CB_STAT] & wide;
        dec.bank     = (mode == AMODE_18) ? cmd_byte[BANK_W-1:0] : '0;
    end
endmodule

// File: rtl/bchan_readback.sv
module bchan_readback
    import bchan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              reload,
    input  logic              reload_ext,
    input  logic              cur_ext,
    input  logic [CH_AW-1:0]  addr,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam int PADDED_W = BYTE_W * (1 << RBP_W);

    logic [RBP_W-1:0]    ptr_q;
    logic [PADDED_W-1:0] padded;

    assign padded  = PADDED_W'(addr);
    assign rd_byte = padded[ptr_q*BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= RBP_W'(1);
        end else if (reload) begin
            ptr_q <= reload_ext ? RBP_W'(2) : RBP_W'(1);
        end else if (rd_stb) begin
            if (ptr_q == '0)
                ptr_q <= cur_ext ? RBP_W'(2) : RBP_W'(1);
            else
                ptr_q <= ptr_q - RBP_W'(1);
        end
    end
endmodule

// File: rtl/bchan_mover.sv
module bchan_mover
    import bchan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              dir_rd,
    input  logic              flush,
    output logic              step,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    output logic [BYTE_W-1:0] dev_out_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready,
    input  logic [BYTE_W-1:0] dev_in_data
);
    logic [BYTE_W-1:0] hold_q;
    logic              full_q;
    logic              fill;

    assign mem_req       = active & (dir_rd ? ~full_q : full_q);
    assign mem_we        = ~dir_rd;
    assign mem_wdata     = hold_q;
    assign dev_out_valid = active & dir_rd & full_q;
    assign dev_out_data  = hold_q;
    assign dev_in_ready  = active & ~dir_rd & ~full_q;

    assign fill = dir_rd ? (mem_req & mem_ack) : (dev_in_valid & dev_in_ready);
    assign step = dir_rd ? (dev_out_valid & dev_out_ready) : (mem_req & mem_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (flush || !active) begin
            full_q <= 1'b0;
        end else if (fill) begin
            hold_q <= dir_rd ? mem_rdata : dev_in_data;
            full_q <= 1'b1;
        end else if (step) begin
            full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bytechan_dma.sv
module bytechan_dma
    import bchan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr_mode,
    input  logic [7:0]        cpu_din,
    input  logic              cpu_data_we,
    input  logic              cpu_cmd_we,
    input  logic              cpu_rd,
    output logic [7:0]        cpu_dout,
    output logic              busy,
    output logic              irq,
    output logic              status_from_dev,
    output logic              mem_req,
    output logic              mem_we,
    output logic [19:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    output logic [7:0]        dev_out_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready,
    input  logic [7:0]        dev_in_data
);
    logic [CH_AW-1:0]  sa_q, ea_q;
    logic [WCNT_W-1:0] wcnt_q;
    cmd_state_t        cmd_q;
    logic              irq_q;

    cmd_dec_t   dec;
    logic       cmd_stop, cmd_go, step;
    addr_pair_t cur, loaded, fixed;
    logic [CH_AW:0] next_addr;

    bchan_cmd_decode u_dec (
        .cmd_byte (cpu_din),
        .mode     (addr_mode),
        .dec      (dec)
    );

    assign cmd_stop = cpu_cmd_we & dec.stop;
    assign cmd_go   = cpu_cmd_we & ~dec.stop & dec.go;

    assign cur.sa = sa_q;
    assign cur.ea = ea_q;
    assign loaded = load_step(addr_mode, wcnt_q, cur, cpu_din);
    assign fixed  = go_fixup(addr_mode, wcnt_q, dec.bank, cur);
    assign next_addr = {1'b0, sa_q} + (CH_AW+1)'(1);

    bchan_readback u_rb (
        .clk        (clk),
        .rst        (rst),
        .rd_stb     (cpu_rd),
        .reload     (cmd_stop),
        .reload_ext (dec.ext_rb),
        .cur_ext    (cmd_q.ext_rb),
        .addr       (sa_q),
        .rd_byte    (cpu_dout)
    );

    bchan_mover u_mov (
        .clk           (clk),
        .rst           (rst),
        .active        (cmd_q.go),
        .dir_rd        (cmd_q.dir_rd),
        .flush         (cmd_stop),
        .step          (step),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sa_q   <= '0;
            ea_q   <= '0;
            wcnt_q <= '0;
            cmd_q  <= '0;
            irq_q  <= 1'b0;
        end else if (cmd_stop) begin
            cmd_q.ext_rb   <= dec.ext_rb;
            cmd_q.stat_sel <= dec.stat_sel;
            cmd_q.go       <= 1'b0;
            cmd_q.dir_rd   <= 1'b0;
            irq_q          <= 1'b0;
            wcnt_q         <= '0;
        end else if (cmd_go) begin
            cmd_q.ext_rb   <= 1'b0;
            cmd_q.stat_sel <= 1'b0;
            cmd_q.go       <= 1'b1;
            cmd_q.dir_rd   <= dec.dir_rd;
            sa_q           <= fixed.sa;
            ea_q           <= fixed.ea;
        end else if (step) begin
            if (next_addr > {1'b0, ea_q}) begin
                irq_q        <= 1'b1;
                cmd_q.go     <= 1'b0;
                cmd_q.dir_rd <= 1'b0;
            end else begin
                sa_q <= next_addr[CH_AW-1:0];
            end
        end else if (cpu_data_we && (wcnt_q < byte_limit(addr_mode))) begin
            sa_q   <= loaded.sa;
            ea_q   <= loaded.ea;
            wcnt_q <= wcnt_q + WCNT_W'(1);
        end
    end

    assign busy            = cmd_q.go;
    assign irq             = irq_q;
    assign status_from_dev = ~cmd_q.go & ~cmd_q.stat_sel;
    assign mem_addr        = sa_q;
endmodule

// File: rtl/bytechan_dma_chk.sv
module bytechan_dma_chk
    import bchan_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             irq,
    input logic             mem_req,
    input logic             dev_out_valid,
    input logic             dev_in_ready,
    input logic             status_from_dev,
    input logic             cpu_cmd_we,
    input logic [7:0]       cpu_din,
    input logic [CH_AW-1:0] sa,
    input logic [CH_AW-1:0] ea
);
    assert_req_only_busy_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_dev_hs_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (dev_out_valid || dev_in_ready) |-> busy);

    assert_end_irq_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (!busy && $past(busy)));

    assert_even_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !sa[0]);

    assert_window_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sa <= ea));

    assert_stop_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_cmd_we && cpu_din[CB_STOP]) |=> (!busy && !irq));

    assert_status_route_R11: assert property (@(posedge clk) disable iff (rst)
        status_from_dev |-> !busy);
endmodule

bind bytechan_dma bytechan_dma_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .busy            (busy),
    .irq             (irq),
    .mem_req         (mem_req),
    .dev_out_valid   (dev_out_valid),
    .dev_in_ready    (dev_in_ready),
    .status_from_dev (status_from_dev),
    .cpu_cmd_we      (cpu_cmd_we),
    .cpu_din         (cpu_din),
    .sa              (sa_q),
    .ea              (ea_q)
);

// File: tb/bytechan_dma_bench.sv
module bytechan_dma_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr_mode = 2'd0;
    logic [7:0]  cpu_din = 8'h00;
    logic        cpu_data_we = 1'b0, cpu_cmd_we = 1'b0, cpu_rd = 1'b0;
    logic [7:0]  cpu_dout;
    logic        busy, irq, status_from_dev;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, dev_out_data, dev_in_data;
    logic        dev_out_valid, dev_in_ready;
    logic [7:0]  feed = 8'h00;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [19:0] mlog_addr [0:255];
    logic [7:0]  mlog_data [0:255];
    logic        mlog_we   [0:255];
    logic [7:0]  olog      [0:255];
    int mcnt = 0;
    int ocnt = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memval(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
    endfunction

    assign mem_rdata   = memval(mem_addr);
    assign dev_in_data = 8'hA0 + feed;

    bytechan_dma u_bytechan_dma (
        .clk(clk), .rst(rst), .addr_mode(addr_mode),
        .cpu_din(cpu_din), .cpu_data_we(cpu_data_we), .cpu_cmd_we(cpu_cmd_we),
        .cpu_rd(cpu_rd), .cpu_dout(cpu_dout),
        .busy(busy), .irq(irq), .status_from_dev(status_from_dev),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(1'b1),
        .dev_out_valid(dev_out_valid), .dev_out_ready(1'b1), .dev_out_data(dev_out_data),
        .dev_in_valid(1'b1), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data)
    );

    always @(posedge clk) if (dev_in_ready) feed <= feed + 8'd1;

    always @(negedge clk) begin
        if (mem_req && mcnt < 256) begin
            mlog_addr[mcnt] = mem_addr;
            mlog_data[mcnt] = mem_wdata;
            mlog_we[mcnt]   = mem_we;
            mcnt = mcnt + 1;
        end
        if (dev_out_valid && ocnt < 256) begin
            olog[ocnt] = dev_out_data;
            ocnt = ocnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); cpu_din = b; cpu_data_we = 1'b1;
        @(negedge clk); cpu_data_we = 1'b0;
    endtask

    task automatic wr_cmd(input logic [7:0] b);
        @(negedge clk); cpu_din = b; cpu_cmd_we = 1'b1;
        @(negedge clk); cpu_cmd_we = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk); b = cpu_dout; cpu_rd = 1'b1;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 dev_in_ready R12", dev_in_ready, 0);
        rd_byte(b); chk("R1 first readback", b, 8'h00);
        rd_byte(b); chk("R1 second readback", b, 8'h00);
    endtask

    task automatic t_narrow_read();
        logic [7:0] b;
        int mb, ob;
        addr_mode = 2'd0;
        wr_cmd(8'h08);
        wr_byte(8'h00); wr_byte(8'h10); wr_byte(8'h00); wr_byte(8'h13);
        wr_byte(8'hFF);
        rd_byte(b); chk("R2 start hi", b, 8'h00);
        rd_byte(b); chk("R2 start lo after extra byte", b, 8'h10);
        rd_byte(b); chk("R4 pointer reload to 1", b, 8'h00);
        rd_byte(b);
        mb = mcnt; ob = ocnt;
        wr_cmd(8'h30);
        chk("R12 busy after go", busy, 1);
        wait_idle();
        chk("R10 busy cleared", busy, 0);
        chk("R10 irq set", irq, 1);
        chk("R2 R9 byte count", ocnt - ob, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R9 mem addr", mlog_addr[mb + i], 20'h00010 + i);
            chk("R9 mem read dir", mlog_we[mb + i], 0);
            chk("R9 device byte", olog[ob + i], memval(20'h00010 + i));
        end
        rd_byte(b); chk("R10 last addr hi", b, 8'h00);
        rd_byte(b); chk("R10 last addr lo", b, 8'h13);
    endtask

    task automatic t_odd_start();
        int mb;
        wr_cmd(8'h08);
        chk("R6 stop clears irq", irq, 0);
        wr_byte(8'h00); wr_byte(8'h11); wr_byte(8'h00); wr_byte(8'h12);
        mb = mcnt;
        wr_cmd(8'h30);
        wait_idle();
        chk("R7 even start count", mcnt - mb, 3);
        chk("R7 even start addr", mlog_addr[mb], 20'h00010);
    endtask

    task automatic t_wrap();
        int mb;
        wr_cmd(8'h08);
        wr_byte(8'h00); wr_byte(8'h20); wr_byte(8'h00); wr_byte(8'h05);
        mb = mcnt;
        wr_cmd(8'h30);
        repeat (20) @(negedge clk);
        chk("R8 still busy past end", busy, 1);
        chk("R8 no irq", irq, 0);
        chk("R11 no dev status while busy", status_from_dev, 0);
        chk("R8 third addr", mlog_addr[mb + 2], 20'h00022);
        wr_cmd(8'h08);
        chk("R6 stop clears busy", busy, 0);
        chk("R6 stop leaves irq low", irq, 0);
        chk("R12 no mem_req after stop", mem_req, 0);
    endtask

    task automatic t_wide_write();
        logic [7:0] b;
        logic [7:0] f0;
        int mb;
        addr_mode = 2'd2;
        wr_cmd(8'h08);
        wr_byte(8'h00); wr_byte(8'h01); wr_byte(8'h00);
        wr_byte(8'h00); wr_byte(8'h01); wr_byte(8'h03);
        wr_byte(8'hFF);
        mb = mcnt;
        @(negedge clk); f0 = feed;
        wr_cmd(8'h10);
        wait_idle();
        chk("R3 R9 write count", mcnt - mb, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 write addr", mlog_addr[mb + i], 20'h00100 + i);
            chk("R9 write dir", mlog_we[mb + i], 1);
            chk("R9 write data", mlog_data[mb + i], 8'hA0 + f0 + 8'(i));
        end
        chk("R10 wide irq", irq, 1);
        wr_cmd(8'h48);
        rd_byte(b); chk("R4 ext byte2", b, 8'h00);
        rd_byte(b); chk("R4 ext byte1", b, 8'h01);
        rd_byte(b); chk("R4 ext byte0", b, 8'h03);
        rd_byte(b); chk("R4 ext reload to 2", b, 8'h00);
        rd_byte(b); chk("R4 ext after reload", b, 8'h01);
    endtask

    task automatic t_bank();
        logic [7:0] b;
        int mb;
        addr_mode = 2'd1;
        wr_cmd(8'h08);
        wr_byte(8'h00); wr_byte(8'h40); wr_byte(8'h00); wr_byte(8'h41);
        mb = mcnt;
        wr_cmd(8'h32);
        wait_idle();
        chk("R7 bank count", mcnt - mb, 2);
        chk("R7 bank addr0", mlog_addr[mb], 20'h20040);
        chk("R7 bank addr1", mlog_addr[mb + 1], 20'h20041);
        wr_cmd(8'h48);
        rd_byte(b); chk("R5 ext masked in 18-bit", b, 8'h00);
        rd_byte(b); chk("R5 byte0 after masked ext", b, 8'h41);
    endtask

    task automatic t_status();
        addr_mode = 2'd2;
        wr_cmd(8'h0C);
        chk("R11 status select set", status_from_dev, 0);
        wr_cmd(8'h08);
        chk("R11 status select clear", status_from_dev, 1);
        addr_mode = 2'd0;
        wr_cmd(8'h0C);
        chk("R5 status bit masked narrow", status_from_dev, 1);
        wr_cmd(8'h18);
        chk("R5 stop beats go", busy, 0);
        wr_cmd(8'h00);
        chk("R5 empty command no go", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_narrow_read();
        t_odd_start();
        t_wrap();
        t_wide_write();
        t_bank();
        t_status();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule